// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block is the digital timing controller for a single successive-approximation conversion. It is driven by a fast system clock and a conversion-clock enable, and every phase length is counted in enabled cycles only. A start request, accepted only while the block is idle, begins a conversion that runs three phases in a fixed order. The first is a short sampling phase through the buffer amplifier. The second is a direct sampling phase with the amplifier bypassed, and its length comes from a two-bit code supplied with the start request. The third is a binary-search resolution phase, which drives a trial word towards an external comparator and builds the result one bit at a time.

The analog side of the converter watches the control outputs. These are the channel-latch pulse, the buffer enable, the bypass control, the capacitor connect and the trial word. The comparator answer comes back on a single input, high when the sampled input is at or above the trial word. When the last bit is decided, the block presents the result and raises a one-cycle end-of-conversion pulse.

Top module: `adc_conv_seq`

## Requirements
- R1: A start request is taken only on a cycle where the block is idle and `clk_en` is high. Taking it produces a `ch_latch_o` pulse exactly one clock cycle long, in the cycle after acceptance.
- R2: The buffered sampling phase lasts exactly 2 enabled cycles. During it `buf_en_o`=1, `bypass_o`=0 and `cap_conn_o`=1.
- R3: The bypassed sampling phase follows. Its length in enabled cycles depends on `st_code_i` as captured at start: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16. During it `bypass_o`=1, `buf_en_o`=0 and `cap_conn_o`=1.
- R4: The resolution phase lasts exactly 10 enabled cycles, with `buf_en_o`, `bypass_o` and `cap_conn_o` all low. Its first trial word is 10'h200, which is the MSB alone.
- R5: Each resolution cycle decides one bit, from MSB to LSB. The bit under trial is kept if `cmp_i` is high and cleared if it is low, and the next lower bit is then set for the next trial. With an ideal comparator (`cmp_i` = input ≥ trial), the result equals the input code.
- R6: `eoc_o` is a single-cycle pulse. `result_o` takes its new value in that same cycle and holds it until the next end-of-conversion or reset.
- R7: `busy_o` is high from the cycle after acceptance through the whole conversion, and it is low in the `eoc_o` cycle. A start request while busy is ignored: it does not change phase lengths, result or pulse count.
- R8: Phase counting and bit decisions advance only on enabled cycles. With `clk_en` low, the phase and the trial word hold.
- R9: A synchronous reset (`rst`) returns the block to idle. It clears `busy_o`, every analog control, `ch_latch_o`, `eoc_o`, the trial word and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Conversion-clock enable |
| start_i | input | 1 | Conversion start request |
| st_code_i | input | 2 | Bypassed-sample length code |
| cmp_i | input | 1 | Comparator answer (input ≥ trial) |
| busy_o | output | 1 | Conversion in progress |
| ch_latch_o | output | 1 | One-cycle pulse telling the multiplexer to latch its channel |
| buf_en_o | output | 1 | Buffer amplifier drives the sample capacitor |
| bypass_o | output | 1 | Amplifier bypassed, input drives the capacitor directly |
| cap_conn_o | output | 1 | Sample capacitor connected to the input path |
| trial_o | output | 10 | Current successive-approximation trial word |
| result_o | output | 10 | Last completed conversion result |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The bench runs each length code under a steady enable and under a gappy enable. In each run it counts the enabled cycles spent in every phase. A sequencer that counted raw clocks would stretch or shrink the phases under the gappy pattern, and a wrong length decode would give bypass counts other than 2, 4, 8 or 16. Input codes of all-zeros, all-ones and the values just either side of the MSB boundary expose a search that keeps or drops the wrong bit, or that skips the LSB. The bench also fires a start in the middle of a conversion, holds a start while the enable is low, and resets during sampling. A design that re-armed, stretched its phases, or left a control line or the result set would show it at the outputs.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BUF_SAMPLE,
        PH_DIR_SAMPLE,
        PH_RESOLVE
    } conv_phase_e;

    typedef struct packed {
        logic buf_en;
        logic bypass;
        logic cap_conn;
    } ana_ctrl_t;

    // Bypassed-sample length: 2, 4, 8, 16 ... for code 0, 1, 2, 3 ...
    function automatic int unsigned direct_len(input int unsigned code);
        return 32'd2 << code;
    endfunction

    function automatic ana_ctrl_t phase_controls(input conv_phase_e ph);
        ana_ctrl_t c;
        c = '0;
        case (ph)
            PH_BUF_SAMPLE: begin c.buf_en = 1'b1; c.cap_conn = 1'b1; end
            PH_DIR_SAMPLE: begin c.bypass = 1'b1; c.cap_conn = 1'b1; end
            default:       c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
    import adc_seq_pkg::*;
#(
    parameter int INIT_CYC = 2,
    parameter int ST_W     = 2,
    parameter int RES_BITS = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clk_en,
    input  logic            start,
    input  logic [ST_W-1:0] st_code,
    output conv_phase_e     phase,
    output logic            accept,
    output logic            sar_load,
    output logic            sar_step,
    output logic            sar_last
);
    localparam int MAX_DIR = 2 << ((1 << ST_W) - 1);
    localparam int CNT_W   = $clog2(MAX_DIR + INIT_CYC + RES_BITS + 1);

    conv_phase_e      phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] len_q, len_d;

    assign phase  = phase_q;
    assign accept = (phase_q == PH_IDLE) && clk_en && start;

    always_comb begin
        phase_d  = phase_q;
        cnt_d    = cnt_q;
        len_d    = len_q;
        sar_load = 1'b0;
        sar_step = 1'b0;
        sar_last = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    phase_d = PH_BUF_SAMPLE;
                    cnt_d   = '0;
                    len_d   = CNT_W'(direct_len(32'(st_code)));
                end
            end
            PH_BUF_SAMPLE: begin
                if (clk_en) begin
                    if (cnt_q == CNT_W'(INIT_CYC - 1)) begin
                        phase_d = PH_DIR_SAMPLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_DIR_SAMPLE: begin
                if (clk_en) begin
                    if (cnt_q == len_q - 1'b1) begin
                        phase_d  = PH_RESOLVE;
                        cnt_d    = '0;
                        sar_load = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            PH_RESOLVE: begin
                if (clk_en) begin
                    sar_step = 1'b1;
                    if (cnt_q == CNT_W'(RES_BITS - 1)) begin
                        sar_last = 1'b1;
                        phase_d  = PH_IDLE;
                        cnt_d    = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
        end
    end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  logic                last,
    input  logic                cmp,
    output logic [RES_BITS-1:0] trial,
    output logic [RES_BITS-1:0] result,
    output logic                eoc
);
    localparam int IDX_W = $clog2(RES_BITS);

    logic [RES_BITS-1:0] trial_q, result_q;
    logic [RES_BITS-1:0] decided, next_bit;
    logic [IDX_W-1:0]    idx_q;
    logic                eoc_q;

    // Per-bit decision and next-trial selection
    for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
        assign decided[b]  = (idx_q == IDX_W'(b)) ? (trial_q[b] & cmp) : trial_q[b];
        assign next_bit[b] = (idx_q == IDX_W'(b + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            result_q <= '0;
            idx_q    <= '0;
            eoc_q    <= 1'b0;
        end else begin
            eoc_q <= 1'b0;
            if (load) begin
                trial_q <= {1'b1, {(RES_BITS-1){1'b0}}};
                idx_q   <= IDX_W'(RES_BITS - 1);
            end else if (step) begin
                if (last) begin
                    trial_q  <= decided;
                    result_q <= decided;
                    eoc_q    <= 1'b1;
                end else begin
                    trial_q <= decided | next_bit;
                    idx_q   <= idx_q - 1'b1;
                end
            end
        end
    end

    assign trial  = trial_q;
    assign result = result_q;
    assign eoc    = eoc_q;

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int INIT_CYC = 2,
    parameter int ST_W     = 2,
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clk_en,
    input  logic                start_i,
    input  logic [ST_W-1:0]     st_code_i,
    input  logic                cmp_i,
    output logic                busy_o,
    output logic                ch_latch_o,
    output logic                buf_en_o,
    output logic                bypass_o,
    output logic                cap_conn_o,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                eoc_o
);
    conv_phase_e phase;
    ana_ctrl_t   ctrl;
    logic        accept, sar_load, sar_step, sar_last;
    logic        latch_q;

    adc_phase_ctrl #(
        .INIT_CYC (INIT_CYC),
        .ST_W     (ST_W),
        .RES_BITS (RES_BITS)
    ) i_phase (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .start    (start_i),
        .st_code  (st_code_i),
        .phase    (phase),
        .accept   (accept),
        .sar_load (sar_load),
        .sar_step (sar_step),
        .sar_last (sar_last)
    );

    adc_sar_reg #(
        .RES_BITS (RES_BITS)
    ) i_sar (
        .clk    (clk),
        .rst    (rst),
        .load   (sar_load),
        .step   (sar_step),
        .last   (sar_last),
        .cmp    (cmp_i),
        .trial  (trial_o),
        .result (result_o),
        .eoc    (eoc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) latch_q <= 1'b0;
        else     latch_q <= accept;
    end

    assign ctrl       = phase_controls(phase);
    assign buf_en_o   = ctrl.buf_en;
    assign bypass_o   = ctrl.bypass;
    assign cap_conn_o = ctrl.cap_conn;
    assign busy_o     = (phase != PH_IDLE);
    assign ch_latch_o = latch_q;

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                clk_en,
    input logic                busy_o,
    input logic                ch_latch_o,
    input logic                buf_en_o,
    input logic                bypass_o,
    input logic [RES_BITS-1:0] trial_o,
    input logic [RES_BITS-1:0] result_o,
    input logic                eoc_o
);
    // R2 / R3: buffered and bypassed sampling never overlap
    p_buf_bypass_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(buf_en_o && bypass_o));

    // R6: end-of-conversion lasts one cycle
    p_eoc_single_r6: assert property (@(posedge clk) disable iff (rst)
        eoc_o |=> !eoc_o);

    // R6: result moves only together with end-of-conversion
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!eoc_o && !$past(rst)) |-> $stable(result_o));

    // R7: busy is low in the end-of-conversion cycle
    p_busy_eoc_r7: assert property (@(posedge clk) disable iff (rst)
        eoc_o |-> !busy_o);

    // R8: a disabled cycle freezes the trial word and the sampling controls
    p_hold_no_en_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(clk_en) && !$past(rst)) |->
        ($stable(trial_o) && $stable(buf_en_o) && $stable(bypass_o)));

    // R1: channel-latch pulse is one cycle and the block is then busy
    p_latch_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        ch_latch_o |-> (busy_o && buf_en_o));

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_BITS(RES_BITS)) i_chk (.*);

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       start = 1'b0;
    logic [1:0] st_code = 2'd0;
    logic       cmp;
    logic       busy, ch_latch, buf_en, bypass, cap_conn, eoc;
    logic [9:0] trial, result;
    logic [9:0] vin = 10'd0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    assign cmp = (vin >= trial);

    adc_conv_seq i_adc_conv_seq (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .start_i    (start),
        .st_code_i  (st_code),
        .cmp_i      (cmp),
        .busy_o     (busy),
        .ch_latch_o (ch_latch),
        .buf_en_o   (buf_en),
        .bypass_o   (bypass),
        .cap_conn_o (cap_conn),
        .trial_o    (trial),
        .result_o   (result),
        .eoc_o      (eoc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // vin[13:4], code[3:2], gappy enable[1], mid-run start[0]
    localparam logic [13:0] VEC [0:7] = '{
        {10'd0,    2'd0, 1'b0, 1'b0},
        {10'd1023, 2'd1, 1'b0, 1'b0},
        {10'd512,  2'd2, 1'b1, 1'b0},
        {10'd511,  2'd3, 1'b0, 1'b1},
        {10'd341,  2'd0, 1'b1, 1'b1},
        {10'd682,  2'd2, 1'b0, 1'b0},
        {10'd1,    2'd3, 1'b1, 1'b0},
        {10'd1022, 2'd1, 1'b1, 1'b1}
    };

    task automatic run_conv(input logic [9:0] v, input logic [1:0] code,
                            input bit gappy, input bit inject);
        int n_buf = 0, n_byp = 0, n_busy = 0, n_eoc = 0, n_latch = 0;
        int n_res = 0, first_trial = -1, cap_bad = 0, exp_len;
        bit done = 0;
        exp_len = 2 << code;
        vin = v;
        @(negedge clk);
        st_code = code; start = 1'b1; clk_en = 1'b1;
        for (int k = 0; k < 400 && !done; k++) begin
            logic en_n;
            @(negedge clk);
            start = 1'b0;
            en_n = gappy ? ((k % 3) != 1) : 1'b1;
            if (inject && k == 5) begin
                start = 1'b1; en_n = 1'b1; st_code = 2'd3;
            end
            if (ch_latch) n_latch++;
            if (cap_conn != (buf_en || bypass)) cap_bad++;
            if (busy && !buf_en && !bypass) begin
                if (first_trial < 0) first_trial = trial;
                if (en_n) n_res++;
            end
            if (buf_en && en_n) n_buf++;
            if (bypass && en_n) n_byp++;
            if (busy && en_n) n_busy++;
            if (eoc) begin
                n_eoc++;
                chk(!busy, "R7 busy low at eoc", busy, 0);
                chk(result == v, "R5 result", result, v);
                done = 1;
            end
            clk_en = en_n;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (eoc) n_eoc++;
            if (busy) n_busy += 100;
        end
        chk(done, "R6 eoc seen", done, 1);
        chk(n_eoc == 1, "R6 eoc pulses", n_eoc, 1);
        chk(result == v, "R6 result held", result, v);
        chk(n_latch == 1, "R1 latch pulses", n_latch, 1);
        chk(n_buf == 2, "R2 buffered enabled cycles", n_buf, 2);
        chk(n_byp == exp_len, "R3 bypass enabled cycles", n_byp, exp_len);
        chk(n_res == 10, "R4 resolve enabled cycles", n_res, 10);
        chk(first_trial == 512, "R4 first trial", first_trial, 512);
        chk(cap_bad == 0, "R2 R3 R4 cap connect", cap_bad, 0);
        chk(n_busy == 12 + exp_len, "R7 R8 busy enabled cycles", n_busy, 12 + exp_len);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({busy, ch_latch, buf_en, bypass, cap_conn, eoc} == 6'b0, "R9 reset controls",
            {busy, ch_latch, buf_en, bypass, cap_conn, eoc}, 0);
        chk(result == 0 && trial == 0, "R9 reset result", result, 0);
        rst = 1'b0;

        // R1 / R8: start while clk_en low is not taken
        @(negedge clk);
        start = 1'b1; clk_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !ch_latch, "R1 start ignored without enable", busy, 0);
        start = 1'b0;

        foreach (VEC[i])
            run_conv(VEC[i][13:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);

        // R9: reset in the middle of sampling
        vin = 10'd700;
        @(negedge clk);
        st_code = 2'd3; start = 1'b1; clk_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(bypass, "R3 bypass before reset", bypass, 1);
        rst = 1'b1;
        @(negedge clk);
        chk({busy, ch_latch, buf_en, bypass, cap_conn, eoc} == 6'b0, "R9 mid-run reset controls",
            {busy, ch_latch, buf_en, bypass, cap_conn, eoc}, 0);
        chk(result == 0 && trial == 0, "R9 mid-run reset result", result, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(!busy && !eoc, "R9 stays idle after reset", busy, 0);

        // resumes normally afterwards
        run_conv(10'd700, 2'd0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule